// File: doc/BRIEF.md
# Software Trap and Return Controller

This block executes the two control-transfer steps of a processor's exception model that software starts on purpose: entering a software trap and returning from an exception. On a trap request it saves the address of the following instruction and the current status word, writes a cause code and raises the exception flags in the status word. It then sends the fetch unit to one of two fixed vectors.

On a return request it picks one of two saved contexts, fatal or ordinary, by looking at the status word flags. It restores the status word from that context and sends fetch back to the saved address. The register file that holds the context stays outside the block. The block reads the current values on its inputs and, one cycle after a request, presents the new values together with write enables and a redirect strobe.

Top module: `trap_ret_ctrl`

## Requirements
- R1: While reset is asserted and after it, until the first request, every output is zero except `o_psw`, which holds only the interrupt-disable bit (bit 5 = 1, value 0x20). All strobes and write enables are low.
- R2: One cycle after a trap request, `o_eipc` equals `i_pc + 4` and `o_eipsw` equals `i_psw`, with `o_ctx_we` high.
- R3: One cycle after a trap request, `o_cause[15:0]` equals 0x40 plus the 5-bit trap code, `o_cause[31:16]` equals `i_cause[31:16]`, and `o_cause_we` is high.
- R4: One cycle after a trap request, `o_psw` equals `i_psw` with the exception-pending bit (bit 6) and the interrupt-disable bit (bit 5) set, and `o_psw_we` is high.
- R5: A trap with code 0x00..0x0F redirects to 0x40. A trap with code 0x10..0x1F redirects to 0x50.
- R6: One cycle after a return request, if `i_psw` has the fatal-pending bit (bit 7) set and bit 6 clear, `o_redirect_pc` equals `i_fepc` and `o_psw` equals `i_fepsw`.
- R7: In every other return case, `o_redirect_pc` equals `i_eipc` and `o_psw` equals `i_eipsw`.
- R8: `o_redirect` and `o_psw_we` are high exactly in the cycle after a cycle with a request. A return never raises `o_ctx_we` or `o_cause_we`, and it leaves `o_eipc`, `o_eipsw` and `o_cause` unchanged.
- R9: When trap and return are requested in the same cycle, only the trap is carried out.
- R10: The saved return address wraps modulo 2^32 (a trap at 0xFFFFFFFC saves 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_trap_req | input | 1 | Software trap request |
| i_ret_req | input | 1 | Return-from-exception request |
| i_trap_code | input | 5 | Trap code |
| i_pc | input | 32 | Address of the trap instruction |
| i_psw | input | 32 | Current status word |
| i_eipc | input | 32 | Saved ordinary-exception return address |
| i_eipsw | input | 32 | Saved ordinary-exception status word |
| i_fepc | input | 32 | Saved fatal-exception return address |
| i_fepsw | input | 32 | Saved fatal-exception status word |
| i_cause | input | 32 | Current cause register |
| o_redirect | output | 1 | Fetch redirect strobe |
| o_redirect_pc | output | 32 | Fetch redirect target |
| o_ctx_we | output | 1 | Write enable for saved return address and status |
| o_eipc | output | 32 | New saved return address |
| o_eipsw | output | 32 | New saved status word |
| o_psw_we | output | 1 | Status word write enable |
| o_psw | output | 32 | New status word |
| o_cause_we | output | 1 | Cause register write enable |
| o_cause | output | 32 | New cause register |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 5-bit trap code and status-word flags at bits 5, 6 and 7. Because the code is only five bits wide, every trap code can be tried, so both sides of the vector split and the full cause encoding are covered. All sixteen settings of the top four status bits can also be tried on return, so each pairing of the fatal-pending and exception-pending flags reaches the context selection. Address wrap and a return request made together with a trap are driven directly.

// File: rtl/trap_ret_ctrl.sv
module trap_ret_ctrl #(
  parameter int XLEN     = 32,
  parameter int CODE_W   = 5,
  parameter int ID_BIT   = 5,
  parameter int EP_BIT   = 6,
  parameter int NP_BIT   = 7,
  parameter int CAUSE_W  = 16,
  parameter logic [XLEN-1:0] CAUSE_BASE = 'h40,
  parameter logic [XLEN-1:0] VEC_LO     = 'h40,
  parameter logic [XLEN-1:0] VEC_HI     = 'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_trap_req,
  input  logic              i_ret_req,
  input  logic [CODE_W-1:0] i_trap_code,
  input  logic [XLEN-1:0]   i_pc,
  input  logic [XLEN-1:0]   i_psw,
  input  logic [XLEN-1:0]   i_eipc,
  input  logic [XLEN-1:0]   i_eipsw,
  input  logic [XLEN-1:0]   i_fepc,
  input  logic [XLEN-1:0]   i_fepsw,
  input  logic [XLEN-1:0]   i_cause,
  output logic              o_redirect,
  output logic [XLEN-1:0]   o_redirect_pc,
  output logic              o_ctx_we,
  output logic [XLEN-1:0]   o_eipc,
  output logic [XLEN-1:0]   o_eipsw,
  output logic              o_psw_we,
  output logic [XLEN-1:0]   o_psw,
  output logic              o_cause_we,
  output logic [XLEN-1:0]   o_cause
);

  localparam logic [XLEN-1:0] ID_MASK  = XLEN'(1) << ID_BIT;
  localparam logic [XLEN-1:0] EP_MASK  = XLEN'(1) << EP_BIT;
  localparam logic [XLEN-1:0] INSN_LEN = XLEN'(4);
  localparam int              SPLIT    = 1 << (CODE_W - 1);

  logic            take_trap, take_ret, use_fatal, hi_vec;
  logic [XLEN-1:0] code_ext, cause_lo, vector;

  assign take_trap = i_trap_req;
  assign take_ret  = i_ret_req & ~i_trap_req;
  assign use_fatal = i_psw[NP_BIT] & ~i_psw[EP_BIT];
  assign code_ext  = XLEN'(i_trap_code);
  assign hi_vec    = int'(i_trap_code) >= SPLIT;
  assign vector    = hi_vec ? VEC_HI : VEC_LO;
  assign cause_lo  = CAUSE_BASE + code_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_redirect    <= 1'b0;
      o_redirect_pc <= '0;
      o_ctx_we      <= 1'b0;
      o_eipc        <= '0;
      o_eipsw       <= '0;
      o_psw_we      <= 1'b0;
      o_psw         <= ID_MASK;
      o_cause_we    <= 1'b0;
      o_cause       <= '0;
    end else begin
      o_redirect <= take_trap | take_ret;
      o_psw_we   <= take_trap | take_ret;
      o_ctx_we   <= take_trap;
      o_cause_we <= take_trap;
      if (take_trap) begin
        o_eipc        <= i_pc + INSN_LEN;
        o_eipsw       <= i_psw;
        o_psw         <= i_psw | EP_MASK | ID_MASK;
        o_cause       <= {i_cause[XLEN-1:CAUSE_W], cause_lo[CAUSE_W-1:0]};
        o_redirect_pc <= vector;
      end else if (take_ret) begin
        o_redirect_pc <= use_fatal ? i_fepc : i_eipc;
        o_psw         <= use_fatal ? i_fepsw : i_eipsw;
      end
    end
  end

  p_saved_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    i_trap_req |=> o_ctx_we && o_eipc == $past(i_pc) + INSN_LEN && o_eipsw == $past(i_psw));

  p_cause_high_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    i_trap_req |=> o_cause_we && o_cause[XLEN-1:CAUSE_W] == $past(i_cause[XLEN-1:CAUSE_W]));

  p_flags_raised_r4: assert property (@(posedge clk) disable iff (!rst_n)
    i_trap_req |=> o_psw[EP_BIT] && o_psw[ID_BIT]);

  p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    i_trap_req |=> (o_redirect_pc == VEC_LO || o_redirect_pc == VEC_HI));

  p_fatal_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (i_ret_req && !i_trap_req && i_psw[NP_BIT] && !i_psw[EP_BIT])
      |=> o_redirect_pc == $past(i_fepc) && o_psw == $past(i_fepsw));

  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (i_trap_req || i_ret_req) |=> o_redirect && o_psw_we);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(i_trap_req || i_ret_req) |=> !o_redirect && !o_psw_we && !o_ctx_we && !o_cause_we);

  p_ret_keeps_ctx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (i_ret_req && !i_trap_req) |=> !o_ctx_we && !o_cause_we && $stable(o_eipc) && $stable(o_cause));

endmodule

// File: tb/sim_trap_ret_ctrl.sv
module sim_trap_ret_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_trap_req = 1'b0, i_ret_req = 1'b0;
  logic [4:0]  i_trap_code = '0;
  logic [31:0] i_pc = '0, i_psw = '0, i_eipc = '0, i_eipsw = '0;
  logic [31:0] i_fepc = '0, i_fepsw = '0, i_cause = '0;
  logic        o_redirect, o_ctx_we, o_psw_we, o_cause_we;
  logic [31:0] o_redirect_pc, o_eipc, o_eipsw, o_psw, o_cause;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] last_eipc, last_eipsw, last_cause;

  always #2 clk = ~clk;

  trap_ret_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    i_trap_req = 0; i_ret_req = 0;
    @(negedge clk);
    chk("R8 redirect drops", {31'b0, o_redirect}, 0);
    chk("R8 psw_we drops", {31'b0, o_psw_we}, 0);
    chk("R8 ctx_we drops", {31'b0, o_ctx_we}, 0);
  endtask

  task automatic trap(logic [4:0] code, logic [31:0] pc, logic [31:0] psw,
                      logic [31:0] cause, bit with_ret);
    @(negedge clk);
    i_trap_req = 1; i_ret_req = with_ret; i_trap_code = code;
    i_pc = pc; i_psw = psw; i_cause = cause;
    i_eipc = 32'hDEAD0000; i_fepc = 32'hBEEF0000; i_eipsw = 32'h1; i_fepsw = 32'h2;
    @(negedge clk);
    i_trap_req = 0; i_ret_req = 0;
    last_eipc = pc + 4; last_eipsw = psw;
    last_cause = {cause[31:16], 16'h0040 + {11'b0, code}};
    chk(with_ret ? "R9 redirect" : "R8 redirect", {31'b0, o_redirect}, 1);
    chk("R2 eipc", o_eipc, last_eipc);
    chk("R2 eipsw", o_eipsw, psw);
    chk("R2 ctx_we", {31'b0, o_ctx_we}, 1);
    chk("R3 cause", o_cause, last_cause);
    chk("R3 cause_we", {31'b0, o_cause_we}, 1);
    chk("R4 psw", o_psw, psw | 32'h60);
    chk("R4 psw_we", {31'b0, o_psw_we}, 1);
    chk(with_ret ? "R9 vector" : "R5 vector", o_redirect_pc, code < 16 ? 32'h40 : 32'h50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 redirect", {31'b0, o_redirect}, 0);
    chk("R1 pc", o_redirect_pc, 0);
    chk("R1 eipc", o_eipc, 0);
    chk("R1 eipsw", o_eipsw, 0);
    chk("R1 cause", o_cause, 0);
    chk("R1 psw", o_psw, 32'h20);
    chk("R1 we", {28'b0, o_ctx_we, o_psw_we, o_cause_we, 1'b0}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {31'b0, o_redirect}, 0);
    chk("R1 psw after release", o_psw, 32'h20);

    for (int c = 0; c < 32; c++) begin
      trap(5'(c), 32'h1000_0000 + 32'(c) * 8, 32'(c) * 32'h0101_0013,
           32'hA5C3_0000 | ((32'(c) * 37) & 32'hFFFF), 0);
      if (c % 8 == 7) idle_check();
    end

    trap(5'd3, 32'hFFFF_FFFC, 32'h0, 32'h1234_FFFF, 0);
    chk("R10 wrap", o_eipc, 32'h0);

    for (int k = 0; k < 16; k++) begin
      logic [31:0] psw, ep, es, fp, fs;
      psw = {24'h00AB00 + 24'(k), 4'(k), 4'h3};
      ep = 32'h2000_0000 + 32'(k) * 16; es = 32'h0F00 + 32'(k);
      fp = 32'h3000_0000 + 32'(k) * 16; fs = 32'hF000 + 32'(k);
      @(negedge clk);
      i_ret_req = 1; i_psw = psw; i_eipc = ep; i_eipsw = es; i_fepc = fp; i_fepsw = fs;
      i_cause = 32'hFFFF_FFFF; i_pc = 32'h7777_7777;
      @(negedge clk);
      i_ret_req = 0;
      chk("R8 ret redirect", {31'b0, o_redirect}, 1);
      chk("R8 ret psw_we", {31'b0, o_psw_we}, 1);
      if (psw[7] && !psw[6]) begin
        chk("R6 pc", o_redirect_pc, fp);
        chk("R6 psw", o_psw, fs);
      end else begin
        chk("R7 pc", o_redirect_pc, ep);
        chk("R7 psw", o_psw, es);
      end
      chk("R8 ret ctx_we", {30'b0, o_ctx_we, o_cause_we}, 0);
      chk("R8 ret eipc kept", o_eipc, last_eipc);
      chk("R8 ret eipsw kept", o_eipsw, last_eipsw);
      chk("R8 ret cause kept", o_cause, last_cause);
    end
    idle_check();

    trap(5'd17, 32'h0000_4000, 32'h0000_0080, 32'h0BAD_0000, 1);
    trap(5'd2, 32'h0000_5000, 32'h0000_0000, 32'h0, 1);
    idle_check();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule